// File: doc/BRIEF.md
# I2C Slave Receiver with Two-Phase 10-bit Address Match

This block is an I2C slave that only receives. It recognises a 10-bit slave address, and software helps it do so. Both bus lines are open-drain. The block samples SCL and SDA through synchronisers. It drives each line low only through a pull-down enable. It finds Start and Stop conditions, shifts in bytes MSB first, answers each byte with ACK or NACK on the ninth clock, and stretches the clock by holding SCL low.

A single 8-bit compare register holds one address byte at a time. Software first loads the high byte, in the form `11110 A9 A8 0`. When that byte matches, the block flags an address update and holds SCL low. Software then writes the low address byte, which releases the bus. After the low byte matches, software writes the high byte back. Data bytes then follow. They go to a one-byte receive buffer that has a full flag and an overflow flag. An optional stretch after each data byte waits until software sets a release bit.

The register port has four selects, chosen by `reg_sel`:
- 0: the receive buffer. Reading it clears the full flag.
- 1: the compare register.
- 2: the status word. Writing 1 to bit 3 or bit 4 clears that bit.
- 3: the control word.

Top module: `i2c10_slave_rx`

## Requirements
- R1: After reset the status word reads 0x00, the control word reads 0x01, and both pull-down enables are 0. Status bits: [0] start seen, [1] address update pending, [2] buffer full, [3] interrupt, [4] overflow. Control bits: [0] clock release, [1] stretch enable, [2] interrupt on Start.
- R2: A Start condition (SDA falling while SCL is high) sets status[0]. It also sets the interrupt flag when control[2] is 1. A Start is honoured in any state, including a repeated Start.
- R3: The first byte after a Start is taken as the high address byte. It is ACKed only if it equals the compare register, its top five bits are 11110 and bit 0 (read/write) is 0. After its ninth clock the block sets the update, buffer-full and interrupt flags and copies the byte into the receive buffer. A non-matching byte is NACKed and sets no flag.
- R4: While the update flag is set, `scl_pd_o` is 1. A write to the compare register clears the update flag. SCL is then released, provided control[0] is 1.
- R5: A read of the receive buffer clears the buffer-full flag.
- R6: The second byte is compared against all 8 bits of the compare register. On a match it is ACKed and sets the update, buffer-full and interrupt flags.
- R7: A second byte that does not match is NACKed. It still sets the update and interrupt flags. It leaves the buffer-full flag at 0 and control[0] unchanged.
- R8: A write to the compare register is ignored while the ACK clock of the current byte is in progress. This window runs from the falling SCL edge after bit 8 to the falling edge after the ninth pulse.
- R9: Each data byte is ACKed when the buffer is empty. The byte is stored, and the buffer-full and interrupt flags are set after the falling edge that ends the ninth pulse.
- R10: With control[1] set, each data byte clears control[0], which holds SCL low. Writing control[0] back to 1 releases SCL.
- R11: A data byte that arrives while the buffer is full is NACKed and is not stored. It sets the overflow and interrupt flags.
- R12: A Stop condition (SDA rising while SCL is high) clears status[0] and returns the block to idle. Clocks received before the next Start are neither ACKed nor flagged.
- R13: Writing the status word with bit 3 and/or bit 4 set clears the interrupt and/or overflow flag. Other status bits are not affected by such a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_pd_o | output | 1 | Pull SCL low when 1 |
| sda_pd_o | output | 1 | Pull SDA low when 1 |
| reg_sel | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| irq_o | output | 1 | Interrupt flag |

## Verification
The assertions assume that the bus master keeps each SCL low phase and each SDA setup time much longer than the synchroniser delay. They also assume that the master changes SDA only while SCL is low, except when it forms a Start or a Stop. Under these conditions the block's SDA pull-down changes only while the synchronised SCL is low.

The bench master waits eight system clocks for every phase. It reads back the wired-AND SCL level before it counts a high phase, so that clock stretching is honoured. It also releases SDA before each ACK slot. Compare-register writes meant to test the ignore window are placed inside the low phase of the ninth clock.

// File: rtl/i2c10_pkg.sv
package i2c10_pkg;
    localparam int BYTE_W    = 8;
    localparam int CNT_W     = 4;
    localparam logic [4:0] HI_PREFIX = 5'b11110;

    localparam logic [1:0] SEL_RX   = 2'd0;
    localparam logic [1:0] SEL_ADDR = 2'd1;
    localparam logic [1:0] SEL_STAT = 2'd2;
    localparam logic [1:0] SEL_CTRL = 2'd3;

    localparam logic [BYTE_W-1:0] STAT_W1C_MASK = 8'h18;
    localparam logic [BYTE_W-1:0] CTRL_RESET    = 8'h01;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BITS,
        ST_ACK,
        ST_SKIP
    } rx_state_e;

    typedef enum logic [1:0] {
        PH_HI,
        PH_LO,
        PH_DATA
    } phase_e;

    typedef struct packed {
        rx_state_e         st;
        phase_e            ph;
        logic [BYTE_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
        logic              ack;
        logic [BYTE_W-1:0] rxbuf;
        logic [BYTE_W-1:0] addr;
        logic              start;
        logic              ua;
        logic              bf;
        logic              irq;
        logic              ovf;
        logic [BYTE_W-1:0] ctrl;
        logic              sda_pd;
    } rx_regs_t;
endpackage

// File: rtl/i2c10_sync.sv
module i2c10_sync #(
    parameter int WIDTH   = 2,
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{RST_VAL}};
            else if (STAGES == 1) chain_q <= din[g];
            else chain_q <= {chain_q[STAGES-2:0], din[g]};
        end
        assign dout[g] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/i2c10_cond_det.sv
module i2c10_cond_det (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic start_p,
    output logic stop_p,
    output logic rise_p,
    output logic fall_p
);
    logic scl_d, scl_q, sda_d, sda_q;

    always_comb begin
        scl_d = scl_s;
        sda_d = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_d;
            sda_q <= sda_d;
        end
    end

    assign start_p = scl_q & scl_s & sda_q & ~sda_s;
    assign stop_p  = scl_q & scl_s & ~sda_q & sda_s;
    assign rise_p  = ~scl_q & scl_s;
    assign fall_p  = scl_q & ~scl_s;
endmodule

// File: rtl/i2c10_slave_rx.sv
module i2c10_slave_rx
    import i2c10_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_pd_o,
    output logic       sda_pd_o,
    input  logic [1:0] reg_sel,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq_o
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    logic [1:0] line_s;
    logic       scl_s, sda_s;
    logic       start_p, stop_p, rise_p, fall_p;
    rx_regs_t   q, d;
    logic       match;

    i2c10_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({scl_i, sda_i}),
        .dout (line_s)
    );
    assign scl_s = line_s[1];
    assign sda_s = line_s[0];

    i2c10_cond_det u_cond (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_s  (scl_s),
        .sda_s  (sda_s),
        .start_p(start_p),
        .stop_p (stop_p),
        .rise_p (rise_p),
        .fall_p (fall_p)
    );

    always_comb begin
        unique case (q.ph)
            PH_HI:   match = (q.sh == q.addr) && (q.sh[7:3] == HI_PREFIX) && !q.sh[0];
            PH_LO:   match = (q.sh == q.addr);
            default: match = !q.bf;
        endcase
    end

    always_comb begin
        d = q;

        // register port side effects
        if (reg_wr) begin
            unique case (reg_sel)
                SEL_ADDR: if (q.st != ST_ACK) begin
                    d.addr = reg_wdata;
                    d.ua   = 1'b0;
                end
                SEL_STAT: begin
                    if ((reg_wdata & STAT_W1C_MASK) != '0) begin
                        if (reg_wdata[3]) d.irq = 1'b0;
                        if (reg_wdata[4]) d.ovf = 1'b0;
                    end
                end
                SEL_CTRL: d.ctrl = reg_wdata;
                default: ;
            endcase
        end
        if (reg_rd && reg_sel == SEL_RX) d.bf = 1'b0;

        // bus side
        if (stop_p) begin
            d.st     = ST_IDLE;
            d.start  = 1'b0;
            d.sda_pd = 1'b0;
        end else if (start_p) begin
            d.st     = ST_BITS;
            d.ph     = PH_HI;
            d.cnt    = '0;
            d.start  = 1'b1;
            d.sda_pd = 1'b0;
            if (q.ctrl[2]) d.irq = 1'b1;
        end else begin
            unique case (q.st)
                ST_BITS: begin
                    if (rise_p) begin
                        d.sh  = {q.sh[BYTE_W-2:0], sda_s};
                        d.cnt = q.cnt + 1'b1;
                    end else if (fall_p && q.cnt == LAST_BIT) begin
                        d.ack    = match;
                        d.sda_pd = match;
                        d.st     = ST_ACK;
                    end
                end
                ST_ACK: begin
                    if (fall_p) begin
                        d.sda_pd = 1'b0;
                        d.cnt    = '0;
                        d.irq    = 1'b1;
                        unique case (q.ph)
                            PH_HI: begin
                                if (q.ack) begin
                                    d.ua    = 1'b1;
                                    d.bf    = 1'b1;
                                    d.rxbuf = q.sh;
                                    d.ph    = PH_LO;
                                    d.st    = ST_BITS;
                                end else begin
                                    d.irq = q.irq;
                                    d.st  = ST_SKIP;
                                end
                            end
                            PH_LO: begin
                                d.ua = 1'b1;
                                if (q.ack) begin
                                    d.bf    = 1'b1;
                                    d.rxbuf = q.sh;
                                    d.ph    = PH_DATA;
                                    d.st    = ST_BITS;
                                end else begin
                                    d.st = ST_SKIP;
                                end
                            end
                            default: begin
                                if (q.ack) begin
                                    d.bf    = 1'b1;
                                    d.rxbuf = q.sh;
                                end else begin
                                    d.ovf = 1'b1;
                                end
                                if (q.ctrl[1]) d.ctrl[0] = 1'b0;
                                d.st = ST_BITS;
                            end
                        endcase
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.st     <= ST_IDLE;
            q.ph     <= PH_HI;
            q.ctrl   <= CTRL_RESET;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        unique case (reg_sel)
            SEL_RX:   reg_rdata = q.rxbuf;
            SEL_ADDR: reg_rdata = q.addr;
            SEL_STAT: reg_rdata = {3'b000, q.ovf, q.irq, q.bf, q.ua, q.start};
            default:  reg_rdata = q.ctrl;
        endcase
    end

    // observation points for the checker
    logic       ua_q, bf_q, rel_q, sten_q, in_ack;
    logic [7:0] addr_q;
    assign ua_q   = q.ua;
    assign bf_q   = q.bf;
    assign rel_q  = q.ctrl[0];
    assign sten_q = q.ctrl[1];
    assign in_ack = (q.st == ST_ACK);
    assign addr_q = q.addr;

    assign scl_pd_o = q.ua | ~q.ctrl[0];
    assign sda_pd_o = q.sda_pd;
    assign irq_o    = q.irq;
endmodule

// File: rtl/i2c10_slave_rx_chk.sv
module i2c10_slave_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] reg_sel,
    input logic       reg_wr,
    input logic       reg_rd,
    input logic       scl_s,
    input logic       scl_pd_o,
    input logic       sda_pd_o,
    input logic       ua_q,
    input logic       bf_q,
    input logic       rel_q,
    input logic       sten_q,
    input logic       in_ack,
    input logic [7:0] addr_q
);
    // R3: the ACK drive only moves while SCL is low
    p_sda_moves_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pd_o) |-> !scl_s);

    // R4: pending address update always stretches SCL
    p_ua_holds_scl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ua_q |-> scl_pd_o);

    // R5: buffer read empties the buffer
    p_read_clears_bf_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_sel == 2'd0 && bf_q) |=> !bf_q);

    // R8: compare register frozen during ACK clock
    p_addr_frozen_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 2'd1 && in_ack) |=> $stable(addr_q));

    // R10: release bit drops by hardware only with stretching enabled
    p_rel_drop_needs_sten_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rel_q) && !$past(reg_wr && reg_sel == 2'd3)) |-> $past(sten_q));
endmodule

bind i2c10_slave_rx i2c10_slave_rx_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .reg_sel (reg_sel),
    .reg_wr  (reg_wr),
    .reg_rd  (reg_rd),
    .scl_s   (scl_s),
    .scl_pd_o(scl_pd_o),
    .sda_pd_o(sda_pd_o),
    .ua_q    (ua_q),
    .bf_q    (bf_q),
    .rel_q   (rel_q),
    .sten_q  (sten_q),
    .in_ack  (in_ack),
    .addr_q  (addr_q)
);

// File: tb/sim_i2c10_slave_rx.sv
module sim_i2c10_slave_rx;
    localparam int H = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b0;
    logic       m_sda = 1'b0;
    logic       scl_pd_o, sda_pd_o, irq_o;
    logic [1:0] reg_sel = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       scl_line, sda_line;
    int         compared = 0;
    int         mismatched = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    assign scl_line = ~(m_scl | scl_pd_o);
    assign sda_line = ~(m_sda | sda_pd_o);

    i2c10_slave_rx u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_line),
        .sda_i    (sda_line),
        .scl_pd_o (scl_pd_o),
        .sda_pd_o (sda_pd_o),
        .reg_sel  (reg_sel),
        .reg_wr   (reg_wr),
        .reg_rd   (reg_rd),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .irq_o    (irq_o)
    );

    // behavioural model of the software-visible flags
    bit m_start, m_ua, m_bf, m_irq, m_ovf;
    logic [7:0] m_ctrl;

    function automatic logic [7:0] m_status();
        return {3'b000, m_ovf, m_irq, m_bf, m_ua, m_start};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hw(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] v);
        @(negedge clk);
        reg_sel = sel; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [7:0] v);
        @(negedge clk);
        reg_sel = sel;
        #1 v = reg_rdata;
        reg_rd = (sel == 2'd0);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_scl_high();
        while (!scl_line) @(negedge clk);
    endtask

    task automatic start_c();
        m_sda = 1'b0; hw(H);
        m_scl = 1'b0; wait_scl_high(); hw(H);
        m_sda = 1'b1; hw(H);
        m_scl = 1'b1; hw(H);
    endtask

    task automatic stop_c();
        m_sda = 1'b1; hw(H);
        m_scl = 1'b0; wait_scl_high(); hw(H);
        m_sda = 1'b0; hw(H);
    endtask

    task automatic bit_c(input logic b);
        m_sda = ~b; hw(H);
        m_scl = 1'b0; wait_scl_high(); hw(H);
        m_scl = 1'b1; hw(H);
    endtask

    task automatic byte_c(input logic [7:0] v, input bit poke, output bit acked);
        for (int i = 7; i >= 0; i--) bit_c(v[i]);
        m_sda = 1'b0; hw(2);
        if (poke) wr(2'd1, 8'h55);
        hw(H);
        m_scl = 1'b0; wait_scl_high(); hw(H);
        acked = ~sda_line;
        m_scl = 1'b1; hw(H);
    endtask

    task automatic chk_status(input string req);
        logic [7:0] v;
        rd(2'd2, v);
        chk(req, v, m_status());
    endtask

    task automatic clr_irq();
        wr(2'd2, 8'h08); m_irq = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        bit a;
        m_ctrl = 8'h01;
        hw(5); rst_n = 1'b1; hw(3);

        // R1 reset state
        chk_status("R1");
        rd(2'd3, v); chk("R1 ctrl", v, 8'h01);
        chk("R1 pins", {scl_pd_o, sda_pd_o}, 0);

        wr(2'd3, 8'h05); m_ctrl = 8'h05;
        wr(2'd1, 8'hF4);

        // R2 start
        start_c(); m_start = 1; m_irq = 1;
        chk_status("R2");
        chk("R2 irq pin", irq_o, 1);
        wr(2'd2, 8'h08); m_irq = 0;
        chk_status("R13");

        // R3 high byte, with a compare write poked into its ACK clock (R8)
        byte_c(8'hF4, 1, a); m_ua = 1; m_bf = 1; m_irq = 1;
        chk("R3 ack", a, 1);
        chk_status("R3");
        chk("R4 scl held", scl_pd_o, 1);
        rd(2'd1, v); chk("R8 addr kept", v, 8'hF4);
        rd(2'd0, v); chk("R5 rx", v, 8'hF4); m_bf = 0;
        chk_status("R5");
        clr_irq();
        wr(2'd1, 8'hA5); m_ua = 0;
        chk("R4 scl released", scl_pd_o, 0);

        // R6 low byte
        byte_c(8'hA5, 0, a); m_ua = 1; m_bf = 1; m_irq = 1;
        chk("R6 ack", a, 1);
        chk_status("R6");
        rd(2'd0, v); chk("R6 rx", v, 8'hA5); m_bf = 0;
        clr_irq();
        wr(2'd1, 8'hF4); m_ua = 0;

        // R9 data byte without stretching
        byte_c(8'h3C, 0, a); m_bf = 1; m_irq = 1;
        chk("R9 ack", a, 1);
        chk_status("R9");
        chk("R9 no stretch", scl_pd_o, 0);
        rd(2'd0, v); chk("R9 rx", v, 8'h3C); m_bf = 0;
        clr_irq();

        // R10 stretching
        wr(2'd3, 8'h07);
        byte_c(8'h81, 0, a); m_bf = 1; m_irq = 1;
        chk("R10 ack", a, 1);
        rd(2'd3, v); chk("R10 rel cleared", v, 8'h06);
        chk("R10 scl held", scl_pd_o, 1);
        rd(2'd0, v); chk("R10 rx", v, 8'h81); m_bf = 0;
        wr(2'd3, 8'h05);
        chk("R10 scl released", scl_pd_o, 0);
        clr_irq();

        // R11 overflow
        byte_c(8'h11, 0, a); m_bf = 1; m_irq = 1;
        chk("R11 first ack", a, 1);
        byte_c(8'h22, 0, a); m_ovf = 1;
        chk("R11 nack", a, 0);
        chk_status("R11");
        rd(2'd0, v); chk("R11 kept", v, 8'h11); m_bf = 0;
        wr(2'd2, 8'h18); m_irq = 0; m_ovf = 0;
        chk_status("R13 w1c");

        // R12 stop and ignored traffic
        stop_c(); m_start = 0;
        chk_status("R12 stop");
        byte_c(8'hF4, 0, a);
        chk("R12 ignored ack", a, 0);
        chk_status("R12 ignored");

        // R3 read/write bit set is not a match
        start_c(); m_start = 1; m_irq = 1;
        byte_c(8'hF5, 0, a);
        chk("R3 rw nack", a, 0);
        chk_status("R3 rw");
        clr_irq();

        // R7 low byte mismatch
        start_c(); m_irq = 1;
        clr_irq();
        byte_c(8'hF4, 0, a); m_ua = 1; m_bf = 1; m_irq = 1;
        rd(2'd0, v); m_bf = 0;
        clr_irq();
        wr(2'd1, 8'hA5); m_ua = 0;
        byte_c(8'hA6, 0, a); m_ua = 1; m_irq = 1;
        chk("R7 nack", a, 0);
        chk_status("R7");
        rd(2'd3, v); chk("R7 ctrl", v, 8'h05);
        chk("R7 scl held", scl_pd_o, 1);
        wr(2'd1, 8'hF4); m_ua = 0;
        chk("R7 released", scl_pd_o, 0);
        stop_c();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule